// File: doc/BRIEF.md
# Signed-Count Arithmetic Shifter

This block shifts a 32-bit (long) or 64-bit (quad) two's-complement operand by a signed 8-bit count. The sign of the count picks the direction: a positive count moves bits toward the most significant end and fills with zeros, and a negative count moves them toward the least significant end and fills with copies of the sign bit. A zero count returns the operand unchanged. Counts beyond the operand width saturate: they give all zeros on the left and all sign bits on the right.

Next to the shifted value the block returns four condition flags. The negative and zero flags describe the result. The overflow flag reports a left shift whose true result does not fit in the selected width. The carry flag is always cleared. An execution pipeline uses the block for its arithmetic-shift operation. The source, the count and a width select are presented together, and the result is taken from a register stage one clock later. A parameter can remove that register stage.

Top module: `ash_shift_unit`

## Requirements
- R1: With `size_i` = 0 (long, width W = 32) or 1 (quad, W = 64), a count c with 1 <= c < W gives the operand shifted left by c bits within W bits, with zeros in the low c bits.
- R2: A count c with -(W-1) < c < 0 gives the operand shifted right by |c| bits within W bits, and every vacated upper bit equals the operand's bit W-1.
- R3: A count of zero returns the operand unchanged, with V = 0.
- R4: On a left shift with c < W, V = 1 exactly when the top c+1 bits of the W-bit operand are not all equal. Any count of zero or below gives V = 0.
- R5: A left count of W or more gives a zero result. This covers counts above 32 for long and above 64 for quad, and also the counts equal to W.
- R6: A count of -(W-1) or below (-31 for long, -63 for quad) gives a result in which all W bits equal the operand's bit W-1.
- R7: A left count of W or more gives V = 1 exactly when the W-bit operand is nonzero.
- R8: N equals bit W-1 of the result, Z = 1 exactly when the W-bit result is zero, and C is always 0.
- R9: In long mode only bits 31:0 of `src_i` are used, and `dst_o[63:32]` is always zero.
- R10: With `OUT_REG` = 1 (default), the value and flags appear on the outputs one clock after the inputs are presented. A synchronous active-high `rst` clears the value and all four flags to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 64 | Source operand; long mode uses bits 31:0 |
| count_i | input | 8 | Signed shift count, two's complement |
| size_i | input | 1 | Width select: 0 = long (32), 1 = quad (64) |
| dst_o | output | 64 | Shifted result, zero-extended in long mode |
| flag_n_o | output | 1 | Result negative |
| flag_z_o | output | 1 | Result zero |
| flag_v_o | output | 1 | Left-shift overflow |
| flag_c_o | output | 1 | Carry, always 0 |

## Verification
Every result and flag comes from a single register after the combinational path. So a stimulus applied on a falling edge is captured on the next rising edge and is valid at the falling edge after that. The bench drives each vector on a falling edge and compares the outputs exactly one falling edge later, and then applies the next vector in the same step. The reset check samples on a falling edge after several reset clocks. The sweep covers every count from -128 to 127 in both widths over a set of edge-value and pseudo-random operands, so each saturation and overflow boundary is reached at its exact count.

// File: rtl/ash_pkg.sv
package ash_pkg;

    localparam int unsigned OPW    = 64;
    localparam int unsigned LONG_W = OPW / 2;
    localparam int unsigned CNT_W  = 8;
    localparam int unsigned SH_W   = $clog2(OPW);

    typedef enum logic {
        SZ_LONG = 1'b0,
        SZ_QUAD = 1'b1
    } size_e;

    // decoded count: direction, clamped barrel amount, raw magnitude
    typedef struct packed {
        logic             left;
        logic             sat_zero;
        logic [SH_W-1:0]  amt;
        logic [CNT_W-1:0] mag;
    } shift_ctl_t;

    typedef struct packed {
        logic [OPW-1:0] value;
        logic           n;
        logic           z;
        logic           v;
        logic           c;
    } ash_out_t;

    // active operand width for a size select, in count-comparison width
    function automatic logic [CNT_W:0] width_of(input size_e sz);
        return (sz == SZ_QUAD) ? (CNT_W+1)'(OPW) : (CNT_W+1)'(LONG_W);
    endfunction

    // bring the selected operand to full width by sign extension
    function automatic logic [OPW-1:0] widen(input size_e sz, input logic [OPW-1:0] src);
        return (sz == SZ_QUAD) ? src : {{LONG_W{src[LONG_W-1]}}, src[LONG_W-1:0]};
    endfunction

endpackage

// File: rtl/ash_count_decode.sv
module ash_count_decode
    import ash_pkg::*;
(
    input  logic [CNT_W-1:0] count,
    input  size_e            size,
    output shift_ctl_t       ctl
);
    logic             neg;
    logic [CNT_W-1:0] mag;
    logic [CNT_W:0]   mag_x;
    logic [CNT_W:0]   lim;

    always_comb begin
        neg   = count[CNT_W-1];
        mag   = neg ? (~count + 1'b1) : count;
        mag_x = {1'b0, mag};
        lim   = width_of(size);

        ctl.left     = !neg && (count != '0);
        ctl.mag      = mag;
        ctl.sat_zero = ctl.left && (mag_x >= lim);

        if (ctl.left) begin
            ctl.amt = ctl.sat_zero ? '0 : mag[SH_W-1:0];
        end else if (mag_x >= lim - 1'b1) begin
            ctl.amt = SH_W'(lim - 1'b1);
        end else begin
            ctl.amt = mag[SH_W-1:0];
        end
    end

endmodule

// File: rtl/ash_barrel.sv
module ash_barrel
    import ash_pkg::*;
(
    input  logic [OPW-1:0] opnd,
    input  shift_ctl_t     ctl,
    output logic [OPW-1:0] raw
);
    logic [OPW-1:0] lstage [0:SH_W];
    logic [OPW-1:0] rstage [0:SH_W];

    assign lstage[0] = opnd;
    assign rstage[0] = opnd;

    for (genvar g = 0; g < SH_W; g++) begin : g_stage
        localparam int unsigned STEP = 1 << g;
        assign lstage[g+1] = ctl.amt[g] ? (lstage[g] << STEP) : lstage[g];
        assign rstage[g+1] = ctl.amt[g] ? OPW'($signed(rstage[g]) >>> STEP) : rstage[g];
    end

    always_comb begin
        if (ctl.sat_zero) begin
            raw = '0;
        end else if (ctl.left) begin
            raw = lstage[SH_W];
        end else begin
            raw = rstage[SH_W];
        end
    end

endmodule

// File: rtl/ash_ovf_detect.sv
module ash_ovf_detect
    import ash_pkg::*;
(
    input  logic [OPW-1:0] opnd,
    input  size_e          size,
    input  shift_ctl_t     ctl,
    output logic           ovf
);
    logic [OPW-1:0]  xv;
    logic [SH_W-1:0] lz;
    logic [SH_W-1:0] headroom;
    logic            hit;

    // bits differing from the sign; redundant sign bits show up as leading zeros
    assign xv = opnd ^ {OPW{opnd[OPW-1]}};

    always_comb begin
        lz  = '0;
        hit = 1'b0;
        for (int i = OPW - 2; i >= 0; i--) begin
            if (!hit) begin
                if (xv[i]) hit = 1'b1;
                else       lz  = lz + 1'b1;
            end
        end
    end

    // long operands arrive sign-extended: discount the upper half copies
    assign headroom = (size == SZ_QUAD) ? lz : lz - SH_W'(LONG_W);

    assign ovf = ctl.left && (opnd != '0) &&
                 ({1'b0, ctl.mag} > (CNT_W+1)'(headroom));

endmodule

// File: rtl/ash_flag_gen.sv
module ash_flag_gen
    import ash_pkg::*;
(
    input  logic [OPW-1:0] raw,
    input  size_e          size,
    input  logic           ovf,
    output ash_out_t       res
);
    always_comb begin
        res.value = (size == SZ_QUAD) ? raw : {{LONG_W{1'b0}}, raw[LONG_W-1:0]};
        res.n     = (size == SZ_QUAD) ? raw[OPW-1] : raw[LONG_W-1];
        res.z     = (res.value == '0);
        res.v     = ovf;
        res.c     = 1'b0;
    end

endmodule

// File: rtl/ash_shift_unit.sv
module ash_shift_unit
    import ash_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [OPW-1:0]   src_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic             size_i,
    output logic [OPW-1:0]   dst_o,
    output logic             flag_n_o,
    output logic             flag_z_o,
    output logic             flag_v_o,
    output logic             flag_c_o
);
    size_e          size;
    logic [OPW-1:0] opnd;
    shift_ctl_t     ctl;
    logic [OPW-1:0] raw;
    logic           ovf;
    ash_out_t       res;
    ash_out_t       out_q;

    assign size = size_e'(size_i);
    assign opnd = widen(size, src_i);

    ash_count_decode u_dec (.count(count_i), .size(size), .ctl(ctl));
    ash_barrel       u_bar (.opnd(opnd), .ctl(ctl), .raw(raw));
    ash_ovf_detect   u_ovf (.opnd(opnd), .size(size), .ctl(ctl), .ovf(ovf));
    ash_flag_gen     u_flg (.raw(raw), .size(size), .ovf(ovf), .res(res));

    if (OUT_REG) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) out_q <= '0;
            else     out_q <= res;
        end

        p_reg_latency_r10: assert property (@(posedge clk) disable iff (rst)
            1'b1 |=> (dst_o == $past(res.value)) && (flag_v_o == $past(res.v)));
    end else begin : g_comb
        assign out_q = res;
    end

    assign dst_o    = out_q.value;
    assign flag_n_o = out_q.n;
    assign flag_z_o = out_q.z;
    assign flag_v_o = out_q.v;
    assign flag_c_o = out_q.c;

    p_passthru_r3: assert property (@(posedge clk) disable iff (rst)
        (count_i == '0) |-> (raw == opnd) && !res.v);

    p_left_sat_zero_r5: assert property (@(posedge clk) disable iff (rst)
        ((size_i && $signed(count_i) >= 8'sd64) || (!size_i && $signed(count_i) >= 8'sd32))
        |-> (res.value == '0));

    p_right_sat_sign_r6: assert property (@(posedge clk) disable iff (rst)
        (size_i && $signed(count_i) <= -8'sd63) |-> (res.value == {OPW{src_i[OPW-1]}}));

    p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
        ($signed(count_i) <= 8'sd0) |-> !res.v);

    p_wide_left_ovf_r7: assert property (@(posedge clk) disable iff (rst)
        (size_i && $signed(count_i) >= 8'sd64) |-> (res.v == (src_i != '0)));

    p_long_upper_r9: assert property (@(posedge clk) disable iff (rst)
        !size_i |-> (res.value[OPW-1:LONG_W] == '0));

endmodule

// File: tb/sim_ash_shift_unit.sv
module sim_ash_shift_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic [63:0] src_i;
    logic [7:0]  count_i;
    logic        size_i;
    logic [63:0] dst_o;
    logic        flag_n_o, flag_z_o, flag_v_o, flag_c_o;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    ash_shift_unit u0 (
        .clk(clk), .rst(rst), .src_i(src_i), .count_i(count_i), .size_i(size_i),
        .dst_o(dst_o), .flag_n_o(flag_n_o), .flag_z_o(flag_z_o),
        .flag_v_o(flag_v_o), .flag_c_o(flag_c_o)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h (size=%0b count=%0d src=%h)",
                     tag, act, exp, size_i, $signed(count_i), src_i);
        end
    endtask

    // reference: {value[63:0], n, z, v, c}
    function automatic logic [67:0] model(input logic q, input logic [63:0] src, input int c);
        int w;
        int m;
        logic signed [63:0] s;
        logic signed [63:0] r;
        logic v;
        w = q ? 64 : 32;
        s = q ? src : {{32{src[31]}}, src[31:0]};
        v = 1'b0;
        if (c > 0) begin
            if (c >= w) begin
                r = '0;
                v = (s != 0);
            end else begin
                r = s << c;
                if (!q) r = {{32{r[31]}}, r[31:0]};
                v = ((r >>> c) != s);
            end
        end else if (c < 0) begin
            m = -c;
            if (m > w - 1) m = w - 1;
            r = s >>> m;
        end else begin
            r = s;
        end
        if (!q) r[63:32] = '0;
        return {r, (q ? r[63] : r[31]), (r == 0), v, 1'b0};
    endfunction

    function automatic string value_tag(input logic q, input int c);
        int w;
        w = q ? 64 : 32;
        if (c == 0)       return "R3";
        if (c >= w)       return "R5";
        if (c > 0)        return "R1";
        if (c <= -(w-1))  return "R6";
        return "R2";
    endfunction

    logic [63:0] pats [12];

    initial begin
        logic [63:0] lf;
        logic [67:0] e;
        int          w;
        pats[0]  = 64'h0;
        pats[1]  = 64'h1;
        pats[2]  = 64'hFFFF_FFFF_FFFF_FFFF;
        pats[3]  = 64'h8000_0000_0000_0000;
        pats[4]  = 64'h7FFF_FFFF_FFFF_FFFF;
        pats[5]  = 64'h0000_0000_8000_0000;
        pats[6]  = 64'h1234_5678_4000_0000;
        pats[7]  = 64'hAAAA_AAAA_AAAA_AAAA;
        lf = 64'hC0FF_EE12_3456_789B;
        for (int i = 8; i < 12; i++) begin
            for (int k = 0; k < 13; k++) lf = {lf[62:0], lf[63] ^ lf[62] ^ lf[60] ^ lf[59]};
            pats[i] = lf;
        end

        rst = 1'b1; src_i = '1; count_i = 8'd5; size_i = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R10 reset value", dst_o, 64'h0);
        check("R10 reset flags", {60'h0, flag_n_o, flag_z_o, flag_v_o, flag_c_o}, 64'h0);
        rst = 1'b0;

        for (int q = 0; q < 2; q++) begin
            w = (q == 1) ? 64 : 32;
            for (int p = 0; p < 12; p++) begin
                for (int c = -128; c < 128; c++) begin
                    size_i  = q[0];
                    src_i   = pats[p];
                    count_i = 8'(c);
                    e = model(q[0], pats[p], c);
                    @(posedge clk);
                    @(negedge clk);
                    check({value_tag(q[0], c), " value (R10 one-cycle)"}, dst_o, e[67:4]);
                    check((c >= w) ? "R7 V flag" : "R4 V flag", {63'h0, flag_v_o}, {63'h0, e[1]});
                    check("R8 N/Z/C flags", {61'h0, flag_n_o, flag_z_o, flag_c_o},
                          {61'h0, e[3], e[2], e[0]});
                    if (q == 0) check("R9 long upper half", {32'h0, dst_o[63:32]}, 64'h0);
                end
            end
        end

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule